// File: doc/BRIEF.md
# I2C Controller Event and Interrupt-Enable Register Bank

This block collects the single-cycle event pulses produced by an I2C transfer engine and holds them in a set of 16-bit registers that a host reaches through a plain word-wide read/write port. Each pulse latches a sticky event bit. Software can see the events in two ways. The raw view shows every latched event whatever its enable state, which suits polling loops. The masked view shows only the enabled events and drives the interrupt line.

The interrupt enable mask has no direct write path. One address sets enable bits by writing ones to them, and another address clears enable bits by writing ones to them. Events are cleared by writing ones to the masked view. Writing 0x7FFF there clears everything at once. A separate level input reports whether the bus is between a START and a STOP, and the raw view shows it live. The host port uses a word address: 0 is raw, 1 is masked status, 2 is enable-set and 3 is enable-clear. Reads are combinational and writes take effect at the clock edge.

Top module: `i2c_event_bank`

## Requirements
- R1: After a synchronous active-low reset every event bit and every enable bit is 0, and irq is 0.
- R2: A 1 on evt_pulse[i] latches event bit i in the cycle after the edge that samples it. Event bits are 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 address error and 6 receive overrun. A latched bit stays set until software clears it, and the enable mask has no bearing on this.
- R3: A read of address 0 (raw) returns the latched event bits in bits 6:0 and bus_busy in bit 7.
- R4: A read of address 1 (status) returns the event bits ANDed with the enable mask in bits 6:0, with bit 7 reading 0.
- R5: A write to address 2 sets each enable bit whose data bit is 1 and leaves the others unchanged. Reads of address 2 or 3 return the enable mask in bits 6:0.
- R6: A write to address 3 clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R7: A write to address 1 clears each event bit whose data bit is 1, whether or not that bit is enabled. Data bits that are 0 leave event bits unchanged.
- R8: Writing 0x7FFF to address 1 clears all event bits.
- R9: irq is 1 exactly when at least one event bit is both latched and enabled.
- R10: If an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R11: Raw bit 7 follows bus_busy level and holds no state. A write to address 1 has no effect on it.
- R12: Writes to address 0 are ignored. Bits 15:8 of every register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 2 | Word address of the register |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| evt_pulse | input | 7 | Event pulses from the transfer engine |
| bus_busy | input | 1 | Bus held between START and STOP |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same clock cycle as a write-one-to-clear of that bit. To reach it, the bench drives the pulse and the status write in the same half-cycle, so that one edge samples both, and then checks that the bit is still set. The bench also sweeps all 128 enable masks. For each mask it loads the mask through a full clear followed by a set, and then fires several event patterns. It checks the raw view, the masked view and irq against values it computes itself.

// File: rtl/i2c_evt_pkg.sv
// Package: shared sizes and register addresses for the I2C event bank.
// Assumes a 4-word register window addressed by word.
package i2c_evt_pkg;
    localparam int DATA_W   = 16;
    localparam int NUM_EV   = 7;
    localparam int ADDR_W   = 2;
    localparam int BUSY_BIT = NUM_EV;

    typedef enum logic [ADDR_W-1:0] {
        REG_RAW    = 2'd0,
        REG_STATUS = 2'd1,
        REG_EN_SET = 2'd2,
        REG_EN_CLR = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/i2c_evt_latch.sv
// Sticky event latches: one flop per event. A pulse sets its bit and a
// qualified clear resets it. When both happen at once, the set wins.
// Assumes pulses last one cycle. Longer pulses simply keep the bit set.
module i2c_evt_latch #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pulse,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] state_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold, clear or set one event bit. The set takes priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                state_q[i] <= 1'b0;
            else if (pulse[i])
                state_q[i] <= 1'b1;
            else if (clr_en && clr_bits[i])
                state_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_irq_mask.sv
// Interrupt enable mask. It has no direct write and is changed only by
// write-one-to-set and write-one-to-clear strobes. The two strobes come
// from different addresses, so they are never active together.
module i2c_irq_mask #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask_q
);
    // Update the mask from whichever strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (set_en)
            mask_q <= mask_q | bits;
        else if (clr_en)
            mask_q <= mask_q & ~bits;
    end
endmodule

// File: rtl/i2c_event_bank.sv
// I2C event register bank. It decodes host writes to the event latches and
// the enable mask, and forms the raw view, the masked view and the interrupt.
// Assumes a single-cycle host write strobe and a combinational read.
module i2c_event_bank
    import i2c_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [NUM_EV-1:0] evt_pulse,
    input  logic              bus_busy,
    output logic              irq
);
    localparam int PAD_RAW = DATA_W - NUM_EV - 1;
    localparam int PAD_EV  = DATA_W - NUM_EV;

    logic              wr_status, wr_set, wr_clr;
    logic [NUM_EV-1:0] raw_events;
    logic [NUM_EV-1:0] enable_mask;
    logic [NUM_EV-1:0] masked_events;

    // Decode the host write strobe by address.
    always_comb begin
        wr_status = host_wr && (host_addr == REG_STATUS);
        wr_set    = host_wr && (host_addr == REG_EN_SET);
        wr_clr    = host_wr && (host_addr == REG_EN_CLR);
    end

    i2c_evt_latch #(.N(NUM_EV)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse    (evt_pulse),
        .clr_en   (wr_status),
        .clr_bits (host_wdata[NUM_EV-1:0]),
        .state_q  (raw_events)
    );

    i2c_irq_mask #(.N(NUM_EV)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_set),
        .clr_en (wr_clr),
        .bits   (host_wdata[NUM_EV-1:0]),
        .mask_q (enable_mask)
    );

    // Form the masked view and the interrupt request.
    always_comb begin
        masked_events = raw_events & enable_mask;
        irq           = |masked_events;
    end

    // Read multiplexer for the four registers.
    always_comb begin
        unique case (host_addr)
            REG_RAW:    host_rdata = {{PAD_RAW{1'b0}}, bus_busy, raw_events};
            REG_STATUS: host_rdata = {{PAD_EV{1'b0}}, masked_events};
            default:    host_rdata = {{PAD_EV{1'b0}}, enable_mask};
        endcase
    end
endmodule

// File: rtl/i2c_event_bank_chk.sv
// Checker for i2c_event_bank. It relates host writes and event pulses to the
// latched state and the interrupt. It is attached with bind below.
module i2c_event_bank_chk
    import i2c_evt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [NUM_EV-1:0] evt_pulse,
    input logic              irq,
    input logic [NUM_EV-1:0] raw_q,
    input logic [NUM_EV-1:0] en_q
);
    // R1: a reset cycle leaves events and enables at zero
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0 && en_q == '0));

    // R2 and R10: a pulse always leaves its bit set
    a_r2_pulse_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R5: set writes add bits to the mask
    a_r5_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_EN_SET) |=>
        ((en_q & $past(host_wdata[NUM_EV-1:0])) == $past(host_wdata[NUM_EV-1:0])));

    // R6: clear writes remove bits from the mask
    a_r6_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_EN_CLR) |=>
        ((en_q & $past(host_wdata[NUM_EV-1:0])) == '0));

    // R7: a status write clears bits with no pulse in that cycle
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_STATUS) |=>
        ((raw_q & $past(host_wdata[NUM_EV-1:0] & ~evt_pulse)) == '0));

    // R9: irq tracks latched-and-enabled events
    a_r9_irq_matches: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw_q & en_q) != '0));

    // R12: a write to the raw address changes no state unless a pulse arrives
    a_r12_raw_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_RAW && evt_pulse == '0) |=>
        ($stable(raw_q) && $stable(en_q)));
endmodule

bind i2c_event_bank i2c_event_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .evt_pulse  (evt_pulse),
    .irq        (irq),
    .raw_q      (raw_events),
    .en_q       (enable_mask)
);

// File: tb/i2c_event_bank_tb.sv
module i2c_event_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic [6:0]  evt_pulse = 7'd0;
    logic        bus_busy = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [6:0] m_raw = 7'd0;
    logic [6:0] m_en = 7'd0;

    always #10 clk = ~clk;

    i2c_event_bank u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_pulse(evt_pulse), .bus_busy(bus_busy), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    // One write lasting one clock. It starts at a falling edge and ends at the next.
    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [6:0] p);
        host_addr = a; host_wdata = d; host_wr = 1'b1; evt_pulse = p;
        @(negedge clk);
        host_wr = 1'b0; evt_pulse = 7'd0;
    endtask

    task automatic pulse(input logic [6:0] p);
        evt_pulse = p;
        @(negedge clk);
        evt_pulse = 7'd0;
    endtask

    task automatic check_all(input string req);
        logic [15:0] d;
        rd(2'd0, d); chk({req, " raw"}, d, {8'd0, bus_busy, m_raw});
        rd(2'd1, d); chk({req, " status"}, d, {9'd0, m_raw & m_en});
        rd(2'd2, d); chk({req, " en"}, d, {9'd0, m_en});
        chk({req, " irq"}, {15'd0, irq}, {15'd0, |(m_raw & m_en)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [6:0] pats [4];
        pats[0] = 7'h01; pats[1] = 7'h2A; pats[2] = 7'h55; pats[3] = 7'h7F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1");

        // R2, R3, R4, R5, R6, R8, R9: sweep every enable mask against several patterns
        for (int e = 0; e < 128; e++) begin
            wr(2'd3, 16'h007F, 7'd0); m_en = 7'd0;
            wr(2'd2, 16'(e), 7'd0); m_en = 7'(e);
            rd(2'd3, d); chk("R6 en via clr addr", d, {9'd0, m_en});
            for (int k = 0; k < 4; k++) begin
                pulse(pats[k]); m_raw = m_raw | pats[k];
                check_all("R2/R4/R9");
                wr(2'd1, 16'h7FFF, 7'd0); m_raw = 7'd0;
                check_all("R8");
            end
        end

        // R5: zeros in a set write leave the mask alone; R6: partial clear
        wr(2'd3, 16'h007F, 7'd0); wr(2'd2, 16'h0033, 7'd0); m_en = 7'h33;
        wr(2'd2, 16'h0000, 7'd0);
        check_all("R5");
        wr(2'd3, 16'h0011, 7'd0); m_en = 7'h22;
        check_all("R6");

        // R7: partial W1C, including disabled bits; zero write has no effect
        pulse(7'h7F); m_raw = 7'h7F;
        wr(2'd1, 16'h0055, 7'd0); m_raw = 7'h2A;
        check_all("R7");
        wr(2'd1, 16'h0000, 7'd0);
        check_all("R7 zero write");

        // R10: pulse and clear of the same bit in one cycle
        wr(2'd1, 16'h7FFF, 7'h08); m_raw = 7'h08;
        check_all("R10");
        wr(2'd1, 16'h7FFF, 7'd0); m_raw = 7'd0;

        // R11: busy level shows live and survives a status clear
        bus_busy = 1'b1; #1;
        check_all("R11 busy high");
        wr(2'd1, 16'h7FFF, 7'd0);
        check_all("R11 after clear");
        bus_busy = 1'b0; #1;
        check_all("R11 busy low");

        // R12: raw address writes ignored, upper bits zero
        pulse(7'h14); m_raw = 7'h14;
        wr(2'd0, 16'hFFFF, 7'd0);
        check_all("R12");
        wr(2'd2, 16'hFF80, 7'd0);
        check_all("R12 upper set bits");
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); chk("R12 upper zero", {d[15:8], 8'd0}, 16'd0);
        end

        // R1: reset again mid-run
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        m_raw = 7'd0; m_en = 7'd0;
        check_all("R1 re-reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule